// File: doc/BRIEF.md
# Two-by-Two Reconfigurable Compute Tile with Pin Wrapper

This block is a four-element reconfigurable datapath packed behind a small pin budget: eight dedicated inputs, eight outputs and eight bidirectional pins. The elements sit on a 2x2 grid. Each element picks two operands from its four neighbours (north, south, east, west), applies one of four arithmetic or logic operations, and stores the result in its own 8-bit output register. Each element is set up by a 6-bit word. All four words are loaded through one 24-bit serial shift chain.

A mode pin divides the block's operation into two phases. In configuration mode the two low bidirectional pins act as inputs and carry serial data and a shift strobe. In execution mode the same two pins turn into outputs: one shows the tail of the shift chain and the other shows a sticky flag that reports a complete load. During execution a byte from the dedicated inputs is captured on a load strobe and fed to every north and west boundary input. A run strobe advances the array by one step. The output pins show one chosen element or the XOR of all four.

Top module: `cgra_tile_top`

## Requirements
- R1: After reset every element register, the input latch and the shift chain are zero, so in execution mode `uo_out` is 0 and `uio_out[1:0]` is 0.
- R2: A shift happens on a clock edge only when `uio_in[5]`=1 (configuration) and `uio_in[1]`=1, and it moves `uio_in[0]` into the chain. The chain runs through element 00, then 01, then 10, then 11, so the first of 24 bits ends in bit 5 of element 11. `uio_out[0]` is bit 5 of element 11's word.
- R3: `uio_oe` is 8'h00 in configuration mode and 8'h03 in execution mode.
- R4: `uio_out[1]` goes to 1 once 24 shifts have been counted since reset, and it stays 1 until the next reset.
- R5: `ui_in` is captured when `uio_in[6]`=1. The captured byte drives the north input of the top row and the west input of the left column.
- R6: The east inputs of the right column and the south inputs of the bottom row are zero. Each internal edge carries the output of the adjacent element.
- R7: In each 6-bit word, bits [5:4] pick operand A and bits [3:2] pick operand B, with 00=north, 01=south, 10=east, 11=west. Bits [1:0] pick the operation: 00=A+B, 01=A-B, 10=A&B, 11=A^B, all modulo 256.
- R8: An element register loads its result only on an edge where `uio_in[2]`=1 and the block is in execution mode. Otherwise it holds.
- R9: When `uio_in[7]`=0, `uo_out` shows element 00, 01, 10 or 11 for `uio_in[4:3]` = 00, 01, 10 or 11.
- R10: When `uio_in[7]`=1, `uo_out` is the XOR of all four element outputs.
- R11: If load and run fall on the same edge, the step uses the byte captured before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ui_in | input | 8 | Data byte to capture |
| uo_out | output | 8 | Selected element output or XOR of all four |
| uio_in | input | 8 | Serial data, shift, run, select, mode, load and XOR controls |
| uio_out | output | 8 | Bit 0 chain tail, bit 1 load-complete flag, others zero |
| uio_oe | output | 8 | Output enables for the bidirectional pins |

## Verification
The capture of a new input byte and an array step can happen on the same edge. The array must then compute from the byte that was held before that edge, because the latch and the element registers update together. The bench sets load and run together in every sweep iteration and presents a new byte each time. It compares all four element outputs with a model that evaluates the step before it updates the latch. A second overlap is a shift strobe while the block is in execution mode. The bench checks that this strobe leaves the chain tail unchanged.

// File: rtl/cgra_pkg.sv
package cgra_pkg;
  localparam int DW     = 8;
  localparam int SEL_W  = 2;
  localparam int OP_W   = 2;
  localparam int CFG_W  = 2 * SEL_W + OP_W;
  localparam int ROWS   = 2;
  localparam int COLS   = 2;
  localparam int NPE    = ROWS * COLS;
  localparam int CHAIN  = NPE * CFG_W;

  typedef enum logic [SEL_W-1:0] {SRC_N = 2'd0, SRC_S = 2'd1, SRC_E = 2'd2, SRC_W = 2'd3} src_e;
  typedef enum logic [OP_W-1:0]  {OP_ADD = 2'd0, OP_SUB = 2'd1, OP_AND = 2'd2, OP_XOR = 2'd3} op_e;

  function automatic logic [DW-1:0] pick_src(input logic [SEL_W-1:0] sel,
      input logic [DW-1:0] n, input logic [DW-1:0] s,
      input logic [DW-1:0] e, input logic [DW-1:0] w);
    case (src_e'(sel))
      SRC_N:   return n;
      SRC_S:   return s;
      SRC_E:   return e;
      default: return w;
    endcase
  endfunction

  function automatic logic [DW-1:0] alu_eval(input logic [OP_W-1:0] op,
      input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (op_e'(op))
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      default: return a ^ b;
    endcase
  endfunction
endpackage

// File: rtl/cgra_pe.sv
module cgra_pe
  import cgra_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_i,
  input  logic          cfg_di,
  output logic          cfg_do,
  input  logic          run_i,
  input  logic [DW-1:0] n_i,
  input  logic [DW-1:0] s_i,
  input  logic [DW-1:0] e_i,
  input  logic [DW-1:0] w_i,
  output logic [DW-1:0] y_o
);
  logic [CFG_W-1:0] cfg_q;
  logic [DW-1:0]    y_q, opa, opb, res;

  always_comb begin
    opa = pick_src(cfg_q[CFG_W-1 -: SEL_W], n_i, s_i, e_i, w_i);
    opb = pick_src(cfg_q[OP_W +: SEL_W], n_i, s_i, e_i, w_i);
    res = alu_eval(cfg_q[OP_W-1:0], opa, opb);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cfg_q <= '0;
    else if (shift_i) cfg_q <= {cfg_q[CFG_W-2:0], cfg_di};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     y_q <= '0;
    else if (run_i) y_q <= res;
  end

  assign cfg_do = cfg_q[CFG_W-1];
  assign y_o    = y_q;

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !shift_i |=> $stable(cfg_q));
  // R8
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !run_i |=> $stable(y_q));
endmodule

// File: rtl/cgra_cfg_ctrl.sv
module cgra_cfg_ctrl #(
  parameter int LEN = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_i,
  output logic done_o
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt_q;
  logic          full;

  assign full = (cnt_q == CW'(LEN));

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (shift_i && !full) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = full;

  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> done_o);
  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !done_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/cgra_tile_top.sv
module cgra_tile_top
  import cgra_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ui_in,
  output logic [7:0] uo_out,
  input  logic [7:0] uio_in,
  output logic [7:0] uio_out,
  output logic [7:0] uio_oe
);
  logic          ser_di, shift_req, run_req, cfg_mode, load_req, xor_view;
  logic [1:0]    out_sel;
  logic          shift_ev, run_ev, load_ev, chain_tail, cfg_done;
  logic [DW-1:0] in_q;
  logic [DW-1:0] pe_y [NPE];
  logic          chain_o [NPE];
  logic [DW-1:0] view;

  assign ser_di    = uio_in[0];
  assign shift_req = uio_in[1];
  assign run_req   = uio_in[2];
  assign out_sel   = uio_in[4:3];
  assign cfg_mode  = uio_in[5];
  assign load_req  = uio_in[6];
  assign xor_view  = uio_in[7];

  assign shift_ev = cfg_mode && shift_req;
  assign run_ev   = !cfg_mode && run_req;
  assign load_ev  = load_req;

  always_ff @(posedge clk) begin
    if (!rst_n)       in_q <= '0;
    else if (load_ev) in_q <= ui_in;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;
      logic [DW-1:0] nn, ss, ee, ww;
      logic          cin;
      if (r == 0) begin : g_n
        assign nn = in_q;
      end else begin : g_n
        assign nn = pe_y[IDX-COLS];
      end
      if (r == ROWS-1) begin : g_s
        assign ss = '0;
      end else begin : g_s
        assign ss = pe_y[IDX+COLS];
      end
      if (c == COLS-1) begin : g_e
        assign ee = '0;
      end else begin : g_e
        assign ee = pe_y[IDX+1];
      end
      if (c == 0) begin : g_w
        assign ww = in_q;
      end else begin : g_w
        assign ww = pe_y[IDX-1];
      end
      if (IDX == 0) begin : g_ci
        assign cin = ser_di;
      end else begin : g_ci
        assign cin = chain_o[IDX-1];
      end
      cgra_pe u_pe (
        .clk(clk), .rst_n(rst_n), .shift_i(shift_ev), .cfg_di(cin),
        .cfg_do(chain_o[IDX]), .run_i(run_ev),
        .n_i(nn), .s_i(ss), .e_i(ee), .w_i(ww), .y_o(pe_y[IDX])
      );
    end
  end

  assign chain_tail = chain_o[NPE-1];

  cgra_cfg_ctrl #(.LEN(CHAIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .shift_i(shift_ev), .done_o(cfg_done)
  );

  always_comb begin
    if (xor_view) begin
      view = '0;
      for (int i = 0; i < NPE; i++) view = view ^ pe_y[i];
    end else begin
      view = pe_y[out_sel];
    end
  end

  assign uo_out  = view;
  assign uio_out = {6'b0, cfg_done, chain_tail};
  assign uio_oe  = cfg_mode ? 8'h00 : 8'h03;

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !load_ev |=> $stable(in_q));
  // R2
  tail_exec_chk: assert property (@(posedge clk) disable iff (!rst_n) !cfg_mode |=> $stable(chain_tail));
  // R8
  pe_cfgmode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |=> ($stable(pe_y[0]) && $stable(pe_y[1]) && $stable(pe_y[2]) && $stable(pe_y[3])));
endmodule

// File: tb/cgra_tile_top_test.sv
module cgra_tile_top_test;
  logic clk = 0, rst_n = 0;
  logic [7:0] ui_in = 0, uo_out, uio_out, uio_oe;
  logic di = 0, sh = 0, run = 0, cmode = 0, load = 0, dbg = 0;
  logic [1:0] osel = 0;
  logic [7:0] uio_in;
  int checks = 0, errors = 0;

  logic [7:0]  m_in;
  logic [7:0]  m_pe [4];
  logic [23:0] m_chain;
  int          m_cnt;

  assign uio_in = {dbg, load, cmode, osel, run, sh, di};
  always #10 clk = ~clk;

  cgra_tile_top uut (.clk(clk), .rst_n(rst_n), .ui_in(ui_in), .uo_out(uo_out),
                     .uio_in(uio_in), .uio_out(uio_out), .uio_oe(uio_oe));

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic [7:0] b_alu(input [1:0] op, input [7:0] a, input [7:0] b);
    case (op) 2'd0: b_alu = a + b; 2'd1: b_alu = a - b; 2'd2: b_alu = a & b; default: b_alu = a ^ b; endcase
  endfunction

  function automatic [7:0] b_src(input [1:0] s, input [7:0] n, input [7:0] so, input [7:0] e, input [7:0] w);
    case (s) 2'd0: b_src = n; 2'd1: b_src = so; 2'd2: b_src = e; default: b_src = w; endcase
  endfunction

  task automatic model_edge();
    logic [7:0] nx [4];
    if (cmode == 0 && run == 1) begin
      for (int i = 0; i < 4; i++) begin
        logic [7:0] n, s, e, w;
        logic [5:0] cw;
        cw = m_chain[i*6 +: 6];
        n = (i < 2) ? m_in : m_pe[(i+2)%4];
        s = (i >= 2) ? 8'h00 : m_pe[(i+2)%4];
        e = (i % 2 == 1) ? 8'h00 : m_pe[(i+1)%4];
        w = (i % 2 == 0) ? m_in : m_pe[(i+3)%4];
        nx[i] = b_alu(cw[1:0], b_src(cw[5:4], n, s, e, w), b_src(cw[3:2], n, s, e, w));
      end
      for (int i = 0; i < 4; i++) m_pe[i] = nx[i];
    end
    if (load) m_in = ui_in;
    if (cmode && sh) begin
      m_chain = {m_chain[22:0], di};
      if (m_cnt < 24) m_cnt++;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_edge();
    @(negedge clk);
  endtask

  task automatic check_view(input string tag);
    for (int k = 0; k < 4; k++) begin
      osel = k[1:0]; dbg = 0; #1;
      chk({tag, " R9 sel"}, uo_out, m_pe[k]);
    end
    dbg = 1; #1;
    chk("R10 xor", uo_out, m_pe[0] ^ m_pe[1] ^ m_pe[2] ^ m_pe[3]);
    dbg = 0; #1;
  endtask

  task automatic check_status(input string tag);
    chk({tag, " R3 oe"}, uio_oe, cmode ? 8'h00 : 8'h03);
    if (!cmode) begin
      chk({tag, " R2 tail"}, uio_out[0], m_chain[23]);
      chk({tag, " R4 done"}, uio_out[1], (m_cnt == 24) ? 1 : 0);
    end
  endtask

  task automatic load_words(input [5:0] w0, input [5:0] w1, input [5:0] w2, input [5:0] w3);
    logic [23:0] s;
    s = {w3, w2, w1, w0};
    cmode = 1; sh = 1; run = 0; load = 0;
    for (int b = 23; b >= 0; b--) begin di = s[b]; tick(); end
    sh = 0; di = 0; cmode = 0; #1;
    chk("R2 load order", m_chain, {w3, w2, w1, w0});
  endtask

  initial begin
    m_in = 0; m_chain = 0; m_cnt = 0;
    for (int i = 0; i < 4; i++) m_pe[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 out", uo_out, 0);
    chk("R1 status", uio_out[1:0], 0);
    check_status("R1");

    // R4: 23 shifts leave the flag low, the 24th sets it
    cmode = 1; sh = 1;
    for (int b = 0; b < 23; b++) begin di = b[0] ^ b[2]; tick(); end
    sh = 0; #1;
    check_status("R4 cfg");
    cmode = 0; #1;
    check_status("R4 at23");
    cmode = 1; sh = 1; di = 1; tick();
    cmode = 0; sh = 0; #1;
    check_status("R4 at24");
    cmode = 1; sh = 1;
    for (int b = 0; b < 5; b++) begin di = b[0]; tick(); end
    cmode = 0; sh = 0; #1;
    check_status("R4 sticky");

    // R2: a shift strobe in execution mode is ignored
    sh = 1; di = ~m_chain[23];
    for (int b = 0; b < 6; b++) tick();
    sh = 0; #1;
    check_status("R2 exec shift");

    // R5 R6 R7 R11 sweep: every word value at element 00, others offset
    for (int k = 0; k < 64; k++) begin
      load_words(k[5:0], 6'((k + 21) % 64), 6'((k + 42) % 64), 6'((k * 5 + 7) % 64));
      ui_in = 8'((k * 37 + 11) % 256); load = 1; tick(); load = 0;
      check_view("R5");
      run = 1; tick();
      check_view("R7 step1");
      // R11: load and run on the same edge
      ui_in = 8'((k * 91 + 200) % 256); load = 1; tick(); load = 0;
      check_view("R11 overlap");
      tick(); run = 0;
      check_view("R6 mesh");
    end

    // R8: hold when run is low, and when run is high in config mode
    ui_in = 8'h5a; load = 1; tick(); load = 0;
    run = 0; tick(); tick();
    check_view("R8 run low");
    cmode = 1; run = 1; tick(); tick();
    cmode = 0; run = 0; #1;
    check_view("R8 cfg mode");
    check_status("R3 exec");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule